// File: doc/BRIEF.md
# USB IN Pipe Receive Bank Controller

This block sits between the packet receiver of a USB host and the CPU. It holds the data of an IN pipe in one or two banks. The receiver writes each good data packet into the oldest free bank. The CPU drains the banks one at a time through a byte read port. Only hardware sets the two status bits. The first bit is a "packet ready" flag that drives an interrupt. The second is an ownership bit that says the CPU-side bank holds data the CPU has not yet returned.

Software handles the two bits in separate steps. Clearing the ready flag only acknowledges the interrupt. Clearing the ownership bit hands the bank back to the receiver. With two banks, that same action moves the CPU pointer to the other bank, and both bits are then reloaded from the fill state of that bank. A packet that the receiver reports as CRC-bad raises a separate error flag and a separate interrupt, and it is still stored and announced like any other packet. When no bank is free, the block shows busy so the receiver can NAK, and a packet started in that state is discarded.

Top module: `usb_in_pipe_rxbuf`

## Requirements
- R1: After reset, rx_busy is 0. rcv_flag, own_flag, crc_flag, both interrupts and rd_avail are also 0, and cpu_bank is 0.
- R2: In the cycle after rx_done closes an accepted packet whose bank is the CPU bank, rcv_flag and own_flag are both 1. rcv_flag is never 1 while own_flag is 0.
- R3: irq_rcv is 1 exactly when rcv_flag is 1 and the enable from ien_wdata bit 0 is 1. irq_crc is 1 exactly when crc_flag is 1 and the enable from ien_wdata bit 1 is 1. Both enables are stored on ien_wr.
- R4: A flag write with bit 0 equal to 0 clears rcv_flag. own_flag, rd_avail and the stored data are left unchanged.
- R5: A flag write with bit 1 equal to 0 while own_flag is 1 releases the CPU bank. With two banks, cpu_bank then toggles, and rcv_flag and own_flag both take the fill state of the new bank. While own_flag is 0, such a write has no effect.
- R6: With one bank, a release frees that bank and cpu_bank stays 0. Both flags then read 0, and rx_busy drops to 0.
- R7: rx_done with rx_crc_bad on an accepted packet sets crc_flag. A flag write with bit 2 equal to 0 clears it. crc_flag rises only after such an rx_done.
- R8: A CRC-bad packet is still stored and still sets rcv_flag and own_flag like a good one.
- R9: Writing 1 to any flag bit leaves that bit unchanged. Only the receive side can set rcv_flag.
- R10: rx_busy is 1 while the bank the next packet would use is full. A packet started with rx_start while rx_busy is 1 is dropped, and the stored data and rd_avail stay as they were.
- R11: rd_data shows the next unread byte of the CPU bank, in arrival order. Each rd_en advances to the following byte. rd_avail equals the stored count minus the bytes read, and it is 0 while own_flag is 0.
- R12: Bytes beyond BANK_BYTES in one packet are discarded. The stored count saturates at BANK_BYTES, which rd_avail never exceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_start | input | 1 | Start of a received data packet |
| rx_byte_vld | input | 1 | rx_byte carries a packet byte |
| rx_byte | input | 8 | Received byte |
| rx_done | input | 1 | End of packet |
| rx_crc_bad | input | 1 | Qualifies rx_done: packet failed its CRC |
| rx_busy | output | 1 | No free bank for the next packet (NAK) |
| flag_wr | input | 1 | Flag register write strobe |
| flag_wdata | input | 3 | Bit 0 ready, bit 1 ownership, bit 2 CRC error; 0 clears, 1 keeps |
| ien_wr | input | 1 | Interrupt enable write strobe |
| ien_wdata | input | 2 | Bit 0 ready enable, bit 1 CRC error enable |
| rd_en | input | 1 | Advance the read port by one byte |
| rcv_flag | output | 1 | Packet ready flag |
| own_flag | output | 1 | CPU owns the current bank |
| crc_flag | output | 1 | CRC error flag |
| rcv_ie | output | 1 | Stored ready enable |
| crc_ie | output | 1 | Stored CRC error enable |
| irq_rcv | output | 1 | Packet ready interrupt |
| irq_crc | output | 1 | CRC error interrupt |
| rd_data | output | 8 | Next unread byte of the CPU bank |
| rd_avail | output | $clog2(BANK_BYTES+1) | Unread bytes in the CPU bank |
| cpu_bank | output | 1 | Index of the CPU-side bank |

## Verification
The bench sends packets in several patterns. A short good packet shows that both flags are set and that the interrupt follows. A CRC-bad packet that lands in the second bank while the first is still held shows that the error flag is independent of the ready flag and that flags of a non-current bank stay hidden. A third packet with both banks full shows the drop path, and an oversize packet shows truncation. A two-bank and a one-bank instance receive the same stimulus. Their flags after each release show the difference between rotating to a filled bank and freeing the only bank. Writes of all ones, ready-only clears and releases with nothing owned check that each software action touches only its own bit.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
   // flag register bit positions (software writes 0 to clear)
   localparam int FLG_RCV = 0;
   localparam int FLG_OWN = 1;
   localparam int FLG_CRC = 2;
   localparam int FLG_W   = 3;
   // interrupt enable bit positions
   localparam int IEN_RCV = 0;
   localparam int IEN_CRC = 1;
   localparam int IEN_W   = 2;

   typedef enum logic [1:0] {
      WR_IDLE = 2'd0,
      WR_FILL = 2'd1,
      WR_DROP = 2'd2
   } wr_state_e;
endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
   parameter int NUM_BANKS  = 2,
   parameter int BANK_BYTES = 64,
   localparam int AW = $clog2(BANK_BYTES)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic          wr_bank,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_byte,
   input  logic          rd_bank,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data
);
   logic [7:0] rd_word [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [7:0] mem [BANK_BYTES];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_bank == 1'(b))) mem[wr_addr] <= wr_byte;
      end
      assign rd_word[b] = mem[rd_addr];
   end

   assign rd_data = rd_word[rd_bank];
endmodule

// File: rtl/rxbuf_wr_ctrl.sv
module rxbuf_wr_ctrl
   import rxbuf_pkg::*;
#(
   parameter int NUM_BANKS  = 2,
   parameter int BANK_BYTES = 64,
   localparam int AW    = $clog2(BANK_BYTES),
   localparam int CNT_W = $clog2(BANK_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_start,
   input  logic             rx_byte_vld,
   input  logic [7:0]       rx_byte,
   input  logic             rx_done,
   input  logic             rx_crc_bad,
   input  logic             wp_full,
   output logic             wp,
   output logic             wr_en,
   output logic [AW-1:0]    wr_addr,
   output logic [7:0]       wr_byte,
   output logic             cmp_vld,
   output logic [CNT_W-1:0] cmp_cnt,
   output logic             cmp_crc,
   output logic             active
);
   wr_state_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             wp_nxt;
   logic             room;

   if (NUM_BANKS == 2) begin : g_rot
      assign wp_nxt = ~wp;
   end else begin : g_fix
      assign wp_nxt = 1'b0;
   end

   assign room    = cnt_q < CNT_W'(BANK_BYTES);
   assign active  = (st_q == WR_FILL);
   assign wr_en   = active && rx_byte_vld && !rx_start && !rx_done && room;
   assign wr_addr = cnt_q[AW-1:0];
   assign wr_byte = rx_byte;
   assign cmp_vld = active && rx_done && !rx_start;
   assign cmp_cnt = cnt_q;
   assign cmp_crc = rx_crc_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= WR_IDLE;
         cnt_q <= '0;
         wp    <= 1'b0;
      end else if (rx_start) begin
         st_q  <= wp_full ? WR_DROP : WR_FILL;
         cnt_q <= '0;
      end else if (rx_done) begin
         st_q <= WR_IDLE;
         if (active) wp <= wp_nxt;
      end else if (wr_en) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/rxbuf_track.sv
module rxbuf_track
   import rxbuf_pkg::*;
#(
   parameter int NUM_BANKS  = 2,
   parameter int BANK_BYTES = 64,
   localparam int CNT_W = $clog2(BANK_BYTES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmp_vld,
   input  logic                 cmp_bank,
   input  logic [CNT_W-1:0]     cmp_cnt,
   input  logic                 cmp_crc,
   input  logic                 flag_wr,
   input  logic [FLG_W-1:0]     flag_wdata,
   input  logic                 ien_wr,
   input  logic [IEN_W-1:0]     ien_wdata,
   input  logic                 rd_en,
   output logic [NUM_BANKS-1:0] bank_full,
   output logic                 cp,
   output logic                 rcv_q,
   output logic                 own_q,
   output logic                 crc_q,
   output logic [IEN_W-1:0]     ien_q,
   output logic [CNT_W-1:0]     idx_q,
   output logic [CNT_W-1:0]     rd_avail
);
   logic [NUM_BANKS-1:0] full_d;
   logic [CNT_W-1:0]     cnt_q [NUM_BANKS];
   logic [CNT_W-1:0]     cnt_d [NUM_BANKS];
   logic                 cp_d, cp_nxt, rcv_d, own_d, crc_d;
   logic [CNT_W-1:0]     idx_d;
   logic                 release_b;

   if (NUM_BANKS == 2) begin : g_rot
      assign cp_nxt = ~cp;
   end else begin : g_fix
      assign cp_nxt = 1'b0;
   end

   assign release_b = flag_wr && !flag_wdata[FLG_OWN] && own_q;

   always_comb begin
      full_d = bank_full;
      cnt_d  = cnt_q;
      cp_d   = cp;
      rcv_d  = rcv_q;
      own_d  = own_q;
      crc_d  = crc_q;
      idx_d  = idx_q;
      if (cmp_vld) begin
         full_d[cmp_bank] = 1'b1;
         cnt_d[cmp_bank]  = cmp_cnt;
      end
      if (flag_wr && !flag_wdata[FLG_CRC]) crc_d = 1'b0;
      if (cmp_vld && cmp_crc) crc_d = 1'b1;
      if (release_b) begin
         full_d[cp] = 1'b0;
         cp_d       = cp_nxt;
         idx_d      = '0;
         rcv_d      = full_d[cp_d];
         own_d      = full_d[cp_d];
      end else begin
         if (flag_wr && !flag_wdata[FLG_RCV]) rcv_d = 1'b0;
         if (cmp_vld && (cmp_bank == cp)) begin
            rcv_d = 1'b1;
            own_d = 1'b1;
         end
         if (rd_en && own_q && (idx_q < cnt_q[cp])) idx_d = idx_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_full <= '0;
         for (int b = 0; b < NUM_BANKS; b++) cnt_q[b] <= '0;
         cp    <= 1'b0;
         rcv_q <= 1'b0;
         own_q <= 1'b0;
         crc_q <= 1'b0;
         idx_q <= '0;
         ien_q <= '0;
      end else begin
         bank_full <= full_d;
         for (int b = 0; b < NUM_BANKS; b++) cnt_q[b] <= cnt_d[b];
         cp    <= cp_d;
         rcv_q <= rcv_d;
         own_q <= own_d;
         crc_q <= crc_d;
         idx_q <= idx_d;
         if (ien_wr) ien_q <= ien_wdata;
      end
   end

   assign rd_avail = own_q ? (cnt_q[cp] - idx_q) : '0;
endmodule

// File: rtl/usb_in_pipe_rxbuf.sv
module usb_in_pipe_rxbuf
   import rxbuf_pkg::*;
#(
   parameter int NUM_BANKS  = 2,
   parameter int BANK_BYTES = 64
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               rx_start,
   input  logic                               rx_byte_vld,
   input  logic [7:0]                         rx_byte,
   input  logic                               rx_done,
   input  logic                               rx_crc_bad,
   output logic                               rx_busy,
   input  logic                               flag_wr,
   input  logic [2:0]                         flag_wdata,
   input  logic                               ien_wr,
   input  logic [1:0]                         ien_wdata,
   input  logic                               rd_en,
   output logic                               rcv_flag,
   output logic                               own_flag,
   output logic                               crc_flag,
   output logic                               rcv_ie,
   output logic                               crc_ie,
   output logic                               irq_rcv,
   output logic                               irq_crc,
   output logic [7:0]                         rd_data,
   output logic [$clog2(BANK_BYTES+1)-1:0]    rd_avail,
   output logic                               cpu_bank
);
   localparam int AW    = $clog2(BANK_BYTES);
   localparam int CNT_W = $clog2(BANK_BYTES + 1);

   if (NUM_BANKS != 1 && NUM_BANKS != 2) begin : g_bad_banks
      $error("NUM_BANKS must be 1 or 2");
   end
   if (BANK_BYTES < 2) begin : g_bad_depth
      $error("BANK_BYTES must be at least 2");
   end

   logic                 wp, wr_en, cmp_vld, cmp_crc, wr_active;
   logic [AW-1:0]        wr_addr;
   logic [7:0]           wr_byte;
   logic [CNT_W-1:0]     cmp_cnt, idx;
   logic [NUM_BANKS-1:0] bank_full;
   logic [IEN_W-1:0]     ien;

   rxbuf_wr_ctrl #(.NUM_BANKS(NUM_BANKS), .BANK_BYTES(BANK_BYTES)) u_wr (
      .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_byte_vld(rx_byte_vld),
      .rx_byte(rx_byte), .rx_done(rx_done), .rx_crc_bad(rx_crc_bad),
      .wp_full(rx_busy), .wp(wp), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_byte(wr_byte), .cmp_vld(cmp_vld), .cmp_cnt(cmp_cnt),
      .cmp_crc(cmp_crc), .active(wr_active)
   );

   rxbuf_track #(.NUM_BANKS(NUM_BANKS), .BANK_BYTES(BANK_BYTES)) u_trk (
      .clk(clk), .rst_n(rst_n), .cmp_vld(cmp_vld), .cmp_bank(wp),
      .cmp_cnt(cmp_cnt), .cmp_crc(cmp_crc), .flag_wr(flag_wr),
      .flag_wdata(flag_wdata), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
      .rd_en(rd_en), .bank_full(bank_full), .cp(cpu_bank), .rcv_q(rcv_flag),
      .own_q(own_flag), .crc_q(crc_flag), .ien_q(ien), .idx_q(idx),
      .rd_avail(rd_avail)
   );

   rxbuf_store #(.NUM_BANKS(NUM_BANKS), .BANK_BYTES(BANK_BYTES)) u_mem (
      .clk(clk), .wr_en(wr_en), .wr_bank(wp), .wr_addr(wr_addr),
      .wr_byte(wr_byte), .rd_bank(cpu_bank), .rd_addr(idx[AW-1:0]),
      .rd_data(rd_data)
   );

   assign rx_busy = bank_full[wp];
   assign rcv_ie  = ien[IEN_RCV];
   assign crc_ie  = ien[IEN_CRC];
   assign irq_rcv = rcv_flag & rcv_ie;
   assign irq_crc = crc_flag & crc_ie;
endmodule

// File: rtl/rxbuf_chk.sv
module rxbuf_chk #(
   parameter int BANK_BYTES = 64,
   localparam int CNT_W = $clog2(BANK_BYTES + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_start,
   input logic             rx_done,
   input logic             rx_crc_bad,
   input logic             rx_busy,
   input logic             flag_wr,
   input logic [2:0]       flag_wdata,
   input logic             rcv_flag,
   input logic             own_flag,
   input logic             crc_flag,
   input logic [CNT_W-1:0] rd_avail,
   input logic             fill_active
);
   // R2
   rcv_needs_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rcv_flag |-> own_flag);

   // R9
   rcv_set_by_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rcv_flag) |-> ($past(rx_done) || $past(flag_wr && !flag_wdata[1])));

   // R7
   crc_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crc_flag) |-> $past(rx_done && rx_crc_bad));

   // R8
   rcv_despite_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !rx_start && fill_active && !own_flag) |=> rcv_flag);

   // R10
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_start && rx_busy) |=> !fill_active);

   // R12
   avail_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_avail <= CNT_W'(BANK_BYTES));
endmodule

bind usb_in_pipe_rxbuf rxbuf_chk #(.BANK_BYTES(BANK_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_done(rx_done),
   .rx_crc_bad(rx_crc_bad), .rx_busy(rx_busy), .flag_wr(flag_wr),
   .flag_wdata(flag_wdata), .rcv_flag(rcv_flag), .own_flag(own_flag),
   .crc_flag(crc_flag), .rd_avail(rd_avail), .fill_active(wr_active)
);

// File: tb/usb_in_pipe_rxbuf_tb_top.sv
module usb_in_pipe_rxbuf_tb_top;
   localparam int BB = 8;
   localparam int CW = $clog2(BB + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic rx_start = 0, rx_byte_vld = 0, rx_done = 0, rx_crc_bad = 0;
   logic [7:0] rx_byte = '0;
   logic flag_wr = 0, ien_wr = 0, rd_en = 0;
   logic [2:0] flag_wdata = '0;
   logic [1:0] ien_wdata = '0;

   logic busy, rcv, own, crc, rie, cie, irq_r, irq_c, cpub;
   logic [7:0] rd_data;
   logic [CW-1:0] avail;
   logic s_busy, s_rcv, s_own, s_crc, s_rie, s_cie, s_irq_r, s_irq_c, s_cpub;
   logic [7:0] s_rd_data;
   logic [CW-1:0] s_avail;

   int total = 0, bad = 0, mfull = 0;
   logic [7:0] exp_q [$];

   always #2 clk = ~clk;

   usb_in_pipe_rxbuf #(.NUM_BANKS(2), .BANK_BYTES(BB)) dut_i (
      .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_byte_vld(rx_byte_vld),
      .rx_byte(rx_byte), .rx_done(rx_done), .rx_crc_bad(rx_crc_bad), .rx_busy(busy),
      .flag_wr(flag_wr), .flag_wdata(flag_wdata), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
      .rd_en(rd_en), .rcv_flag(rcv), .own_flag(own), .crc_flag(crc), .rcv_ie(rie),
      .crc_ie(cie), .irq_rcv(irq_r), .irq_crc(irq_c), .rd_data(rd_data),
      .rd_avail(avail), .cpu_bank(cpub));

   usb_in_pipe_rxbuf #(.NUM_BANKS(1), .BANK_BYTES(BB)) dut1_i (
      .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_byte_vld(rx_byte_vld),
      .rx_byte(rx_byte), .rx_done(rx_done), .rx_crc_bad(rx_crc_bad), .rx_busy(s_busy),
      .flag_wr(flag_wr), .flag_wdata(flag_wdata), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
      .rd_en(rd_en), .rcv_flag(s_rcv), .own_flag(s_own), .crc_flag(s_crc), .rcv_ie(s_rie),
      .crc_ie(s_cie), .irq_rcv(s_irq_r), .irq_crc(s_irq_c), .rd_data(s_rd_data),
      .rd_avail(s_avail), .cpu_bank(s_cpub));

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr_flags(logic [2:0] v);
      flag_wdata = v; flag_wr = 1'b1; tick(); flag_wr = 1'b0;
   endtask

   // driver: sends a packet and pushes the bytes the block must keep
   task automatic send_pkt(int n, int base, bit crc_bad, output bit acc);
      acc = (mfull < 2);
      rx_start = 1'b1; tick(); rx_start = 1'b0;
      for (int i = 0; i < n; i++) begin
         rx_byte = 8'(base + i); rx_byte_vld = 1'b1; tick();
         if (acc && i < BB) exp_q.push_back(8'(base + i));
      end
      rx_byte_vld = 1'b0;
      rx_done = 1'b1; rx_crc_bad = crc_bad; tick();
      rx_done = 1'b0; rx_crc_bad = 1'b0;
      if (acc) mfull++;
   endtask

   // monitor: pops expected bytes and compares against the read port
   task automatic read_n(int n);
      for (int i = 0; i < n; i++) begin
         if (exp_q.size() == 0) chk("R11 queue empty", 1, 0);
         else chk("R11 rd_data", int'(rd_data), int'(exp_q.pop_front()));
         rd_en = 1'b1; tick(); rd_en = 1'b0;
      end
   endtask

   initial begin
      #800000;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      bit acc;
      repeat (3) tick();
      rst_n = 1'b1; tick();
      // R1 reset state
      chk("R1 rcv", rcv, 0); chk("R1 own", own, 0); chk("R1 crc", crc, 0);
      chk("R1 busy", busy, 0); chk("R1 avail", avail, 0); chk("R1 irq", irq_r, 0);
      chk("R1 bank", cpub, 0);

      ien_wdata = 2'b11; ien_wr = 1'b1; tick(); ien_wr = 1'b0;
      chk("R3 rcv_ie", rie, 1); chk("R3 crc_ie", cie, 1);

      send_pkt(3, 'h10, 1'b0, acc);
      chk("R2 rcv", rcv, 1); chk("R2 own", own, 1);
      chk("R3 irq_rcv", irq_r, 1); chk("R11 avail", avail, 3);
      chk("R6 one-bank busy", s_busy, 1);

      send_pkt(5, 'h20, 1'b1, acc);
      chk("R7 crc", crc, 1); chk("R3 irq_crc", irq_c, 1);
      chk("R8 rcv held", rcv, 1); chk("R8 avail A", avail, 3);
      chk("R10 busy", busy, 1); chk("R10 one-bank avail", s_avail, 3);

      send_pkt(4, 'h30, 1'b0, acc);
      chk("R10 dropped accepted", acc, 0);
      chk("R10 busy held", busy, 1); chk("R10 avail held", avail, 3);

      wr_flags(3'b111);
      chk("R9 rcv", rcv, 1); chk("R9 own", own, 1); chk("R9 crc", crc, 1);

      wr_flags(3'b110);
      chk("R4 rcv", rcv, 0); chk("R4 own", own, 1); chk("R4 avail", avail, 3);
      chk("R3 irq off", irq_r, 0);

      read_n(3);
      chk("R11 avail end", avail, 0);

      wr_flags(3'b101); mfull--;
      chk("R5 bank", cpub, 1); chk("R5 rcv reload", rcv, 1);
      chk("R5 own reload", own, 1); chk("R5 avail", avail, 5); chk("R10 busy free", busy, 0);
      chk("R6 bank", s_cpub, 0); chk("R6 own", s_own, 0); chk("R6 rcv", s_rcv, 0);
      chk("R6 busy", s_busy, 0);

      read_n(5); // R8 crc-bad packet data delivered

      wr_flags(3'b011);
      chk("R7 crc clear", crc, 0); chk("R7 irq_crc off", irq_c, 0); chk("R7 own", own, 1);

      wr_flags(3'b101); mfull--;
      chk("R5 bank back", cpub, 0); chk("R5 rcv empty", rcv, 0); chk("R5 own empty", own, 0);

      wr_flags(3'b101);
      chk("R5 no-own release", cpub, 0); chk("R11 avail unowned", avail, 0);

      send_pkt(10, 'h40, 1'b0, acc);
      chk("R12 avail sat", avail, BB); chk("R2 rcv again", rcv, 1);
      read_n(BB);
      chk("R12 avail end", avail, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule